// File: doc/BRIEF.md
# Arithmetic, Logic and Shift Function Unit

This block is a purely combinational function unit that sits between two operand buses and a result bus in a datapath. A 5-bit function code chooses one of three engines: an adder-based arithmetic path, a bitwise logic path, or a one-position shifter that works on the second operand. A final selection step routes the chosen engine's output to the result. Four status flags are produced alongside it: zero, negative, carry and signed overflow.

Inside, a small decoder turns the function code into a struct of strobes: the unit select, the adder operand select, the carry-in, the logic op and the shift op. A datapath module acts on those strobes. The operand width is a parameter.

Top module: `func_unit`

## Requirements
- R1: The function code `fsCode` is split as follows. Bit 4 chooses the shifter. With bit 4 low, bit 3 chooses logic (1) or arithmetic (0). Bits 2:1 pick the operation. Bit 0 is the adder carry-in.
- R2: Arithmetic (`fsCode[4:3]`=00) gives result = A + Y + fsCode[0] modulo 2^WIDTH. Y is 0, B, ~B or all ones when `fsCode[2:1]` is 00, 01, 10 or 11. This makes 00000 pass A, 00001 A+1, 00010 A+B, 00011 A+B+1, 00100 A+~B, 00101 A−B, 00110 A−1 and 00111 pass A.
- R3: For arithmetic operations, `carryFlag` is bit WIDTH of the unwrapped sum A + Y + carry-in.
- R4: For arithmetic operations, `overflowFlag` is 1 exactly when A and Y have the same MSB and the result MSB differs from it.
- R5: Logic (`fsCode[4:3]`=01) gives A AND B, A OR B, A XOR B or NOT A when `fsCode[2:1]` is 00, 01, 10 or 11. `fsCode[0]` has no effect.
- R6: Shift (`fsCode[4]`=1) acts on B. `fsCode[3:2]` set to 01 shifts right by one and 10 shifts left by one; 00 and 11 pass B unchanged. A 0 enters the vacated bit. `fsCode[1:0]` has no effect.
- R7: `carryFlag` and `overflowFlag` are 0 for every logic and shift operation.
- R8: `zeroFlag` is 1 exactly when every result bit is 0.
- R9: `negFlag` equals the result MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, also the shifter input |
| fsCode | input | 5 | Function select code |
| result | output | WIDTH | Selected result |
| carryFlag | output | 1 | Adder carry-out, 0 outside arithmetic |
| overflowFlag | output | 1 | Signed overflow, 0 outside arithmetic |
| zeroFlag | output | 1 | Result is all zeros |
| negFlag | output | 1 | Result MSB |

## Verification
At WIDTH=4, the bench drives every pair of operands under all 32 function codes. This covers every reserved or don't-care field combination, so an ignored bit that leaks into the result shows up as a mismatch. The operand sweep reaches the corners that separate the arithmetic variants. A=0 under decrement tells carry-out from borrow. Sign-boundary pairs such as 7+1 and 8−1 tell overflow apart from carry. B with only its MSB or only its LSB set shows whether the shifter drops the right bit and fills with 0.

// File: rtl/fu_pkg.sv
package fu_pkg;

  localparam int FS_WIDTH = 5;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    Y_ZERO = 2'd0,
    Y_B    = 2'd1,
    Y_NOTB = 2'd2,
    Y_ONES = 2'd3
  } ysel_e;

  typedef enum logic [1:0] {
    LOG_AND  = 2'd0,
    LOG_OR   = 2'd1,
    LOG_XOR  = 2'd2,
    LOG_NOTA = 2'd3
  } logop_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFT  = 2'd2,
    SH_PASS2 = 2'd3
  } shop_e;

  typedef struct packed {
    unit_e  unitSel;
    ysel_e  operandSel;
    logic   carryIn;
    logop_e logicOp;
    shop_e  shiftOp;
  } fu_ctrl_t;

endpackage

// File: rtl/fu_decode.sv
module fu_decode
  import fu_pkg::*;
(
  input  logic [FS_WIDTH-1:0] fsCode,
  output fu_ctrl_t            ctrl
);

  // R1: bit 4 shifter, bit 3 logic/arith, bits 2:1 op, bit 0 carry-in
  always_comb begin
    if (fsCode[4])      ctrl.unitSel = UNIT_SHIFT;
    else if (fsCode[3]) ctrl.unitSel = UNIT_LOGIC;
    else                ctrl.unitSel = UNIT_ARITH;
    ctrl.operandSel = ysel_e'(fsCode[2:1]);
    ctrl.logicOp    = logop_e'(fsCode[2:1]);
    ctrl.shiftOp    = shop_e'(fsCode[3:2]);
    // carry-in only matters on the arithmetic path
    ctrl.carryIn    = fsCode[0] & ~fsCode[4] & ~fsCode[3];
  end

endmodule

// File: rtl/fu_datapath.sv
module fu_datapath
  import fu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  fu_ctrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero,
  output logic             negative
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] yOp;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] shiftRes;
  logic [WIDTH-1:0] shRight;
  logic [WIDTH-1:0] shLeft;

  // adder second operand, per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_ybit
    always_comb begin
      unique case (ctrl.operandSel)
        Y_ZERO:  yOp[i] = 1'b0;
        Y_B:     yOp[i] = opB[i];
        Y_NOTB:  yOp[i] = ~opB[i];
        default: yOp[i] = 1'b1;
      endcase
    end
  end

  assign sumWide = {1'b0, opA} + {1'b0, yOp} + {{WIDTH{1'b0}}, ctrl.carryIn};

  always_comb begin
    unique case (ctrl.logicOp)
      LOG_AND: logicRes = opA & opB;
      LOG_OR:  logicRes = opA | opB;
      LOG_XOR: logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
  end

  assign shRight = {1'b0, opB[MSB:1]};
  assign shLeft  = {opB[MSB-1:0], 1'b0};

  always_comb begin
    unique case (ctrl.shiftOp)
      SH_RIGHT: shiftRes = shRight;
      SH_LEFT:  shiftRes = shLeft;
      default:  shiftRes = opB;
    endcase
  end

  always_comb begin
    result   = sumWide[MSB:0];
    carryOut = 1'b0;
    overflow = 1'b0;
    unique case (ctrl.unitSel)
      UNIT_ARITH: begin
        carryOut = sumWide[WIDTH];
        overflow = (opA[MSB] == yOp[MSB]) && (sumWide[MSB] != opA[MSB]);
      end
      UNIT_LOGIC: result = logicRes;
      default:    result = shiftRes;
    endcase
  end

  assign zero     = (result == '0);
  assign negative = result[MSB];

  // guards on the selected output against the strobes
  always_comb begin
    if (ctrl.unitSel != UNIT_ARITH) begin
      assert_flags_clear_R7: assert (!carryOut && !overflow)
        else $error("carry/overflow set outside arithmetic");
    end
    if (ctrl.unitSel == UNIT_SHIFT && ctrl.shiftOp == SH_LEFT) begin
      assert_left_fill_R6: assert (!result[0] && result[MSB:1] == opB[MSB-1:0])
        else $error("left shift fill wrong");
    end
    if (ctrl.unitSel == UNIT_SHIFT && ctrl.shiftOp == SH_RIGHT) begin
      assert_right_fill_R6: assert (!result[MSB] && result[MSB-1:0] == opB[MSB:1])
        else $error("right shift fill wrong");
    end
    if (ctrl.unitSel == UNIT_ARITH && ctrl.operandSel == Y_ZERO && !ctrl.carryIn) begin
      assert_pass_a_R2: assert (result == opA && !carryOut && !overflow)
        else $error("pass A wrong");
    end
    assert_zero_sign_R8: assert (!(zero && negative))
      else $error("zero and negative both set");
  end

endmodule

// File: rtl/func_unit.sv
module func_unit
  import fu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  input  logic [FS_WIDTH-1:0] fsCode,
  output logic [WIDTH-1:0]    result,
  output logic                carryFlag,
  output logic                overflowFlag,
  output logic                zeroFlag,
  output logic                negFlag
);

  fu_ctrl_t ctrl;

  fu_decode u_decode (
    .fsCode (fsCode),
    .ctrl   (ctrl)
  );

  fu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .carryOut (carryFlag),
    .overflow (overflowFlag),
    .zero     (zeroFlag),
    .negative (negFlag)
  );

endmodule

// File: tb/func_unit_bench.sv
module func_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic [W-1:0] opA, opB;
  logic [4:0] fsCode;
  logic [W-1:0] result;
  logic carryFlag, overflowFlag, zeroFlag, negFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  func_unit #(.WIDTH(W)) u_func_unit (
    .opA(opA), .opB(opB), .fsCode(fsCode),
    .result(result), .carryFlag(carryFlag), .overflowFlag(overflowFlag),
    .zeroFlag(zeroFlag), .negFlag(negFlag)
  );

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s fs=%05b a=%0d b=%0d actual=%0d expected=%0d",
               req, what, fsCode, opA, opB, act, exp);
    end
  endtask

  initial begin
    opA = '0; opB = '0; fsCode = '0;
    for (int fs = 0; fs < 32; fs++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          int y, sum, eF, eC, eV, sel, sh;
          @(negedge clk);
          fsCode = 5'(fs); opA = W'(a); opB = W'(b);
          @(posedge clk);
          #1;
          eC = 0; eV = 0;
          sel = (fs >> 1) & 3;
          if ((fs & 16) != 0) begin
            // R6: shifter on B, field fs[3:2]
            sh = (fs >> 2) & 3;
            if (sh == 1)      eF = b >> 1;
            else if (sh == 2) eF = (b << 1) & MASK;
            else              eF = b;
            checkVal("R6", "shift result", int'(result), eF);
            checkVal("R7", "carry on shift", int'(carryFlag), 0);
            checkVal("R7", "overflow on shift", int'(overflowFlag), 0);
          end else if ((fs & 8) != 0) begin
            // R5: logic ops, carry-in bit ignored
            if (sel == 0)      eF = a & b;
            else if (sel == 1) eF = a | b;
            else if (sel == 2) eF = a ^ b;
            else               eF = (~a) & MASK;
            checkVal("R5", "logic result", int'(result), eF);
            checkVal("R7", "carry on logic", int'(carryFlag), 0);
            checkVal("R7", "overflow on logic", int'(overflowFlag), 0);
          end else begin
            // R1/R2: arithmetic with Y select and carry-in
            if (sel == 0)      y = 0;
            else if (sel == 1) y = b;
            else if (sel == 2) y = (~b) & MASK;
            else               y = MASK;
            sum = a + y + (fs & 1);
            eF = sum & MASK;
            eC = (sum >> W) & 1;
            eV = (((a >> (W-1)) & 1) == ((y >> (W-1)) & 1)) &&
                 (((eF >> (W-1)) & 1) != ((a >> (W-1)) & 1)) ? 1 : 0;
            checkVal("R2", "arith result", int'(result), eF);
            checkVal("R3", "carry", int'(carryFlag), eC);
            checkVal("R4", "overflow", int'(overflowFlag), eV);
          end
          checkVal("R8", "zero flag", int'(zeroFlag), (eF == 0) ? 1 : 0);
          checkVal("R9", "neg flag", int'(negFlag), (eF >> (W-1)) & 1);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule